// File: doc/BRIEF.md
# Two-Write Flash Page Codec

This block lets a flash page be programmed twice between erases. Logical data is split into 2-bit symbols, and each symbol is held in a group of three cells. Because a cell can only be cleared from 1 to 0 until the next erase, the codec uses two codebooks. The first-pass codebook keeps two or three cells set. The second-pass codebook keeps at most one cell set. For any symbol value, the two codewords are bitwise complements of each other.

For each write, the controller supplies the new logical word, a pass selector and the physical word currently stored in the page. One cycle later the block returns the physical word to program and the logical word that the stored contents decode to. On a second-pass write, any symbol whose value does not change keeps its stored cells as they are. Every other symbol is cleared towards its new codeword. The block never asks for a cell to go from 0 to 1. When a group cannot reach its target by clearing cells, the block reports a programming error. A first-pass write to a page that is not erased is refused.

Top module: `wom2_codec`

## Requirements
- R1: A first-pass write (pass_i=0) to an all-ones stored word encodes each symbol as 00→111, 01→110, 10→101, 11→011, and raises no error flag.
- R2: A second-pass write (pass_i=1) encodes each changed symbol as 00→000, 01→001, 10→010, 11→100.
- R3: On a second-pass write, a symbol whose new value equals its decoded stored value keeps its stored 3-bit pattern unchanged.
- R4: Decoding counts the ones in each group. A group with two or three ones decodes through the first-pass codebook, and 111 gives 00. A group with zero or one ones decodes through the second-pass codebook. The decoded word of the stored input appears on data_o.
- R5: Every output bit is 0 wherever the stored word holds 0. No cell is ever raised.
- R6: On a second-pass write, prog_err_o is 1 when any changed group, after clearing, differs from its target codeword. The cleared result is still driven on phys_o.
- R7: A first-pass write to a stored word that is not all ones sets proto_err_o, clears prog_err_o and returns the stored word unchanged. A second-pass write never sets proto_err_o.
- R8: Outputs update on the clock edge that samples req_i=1, and valid_o is high for exactly that following cycle. In a cycle without a request, valid_o and both error flags are 0 and phys_o and data_o hold their values.
- R9: While rst_ni is low, valid_o is 0, both flags are 0, phys_o is all ones and data_o is zero.
- R10: Symbol k maps logical bits [2k+1:2k] to physical bits [3k+2:3k], so symbol 0 sits in physical bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Encode request for the current inputs |
| pass_i | input | 1 | 0 selects the first pass, 1 selects the second pass |
| data_i | input | 16 | New logical word |
| phys_i | input | 24 | Physical word currently stored in the page |
| valid_o | output | 1 | Result of a request is present |
| phys_o | output | 24 | Physical word to program |
| data_o | output | 16 | Logical word decoded from phys_i |
| prog_err_o | output | 1 | A changed group cannot reach its target codeword by clearing cells |
| proto_err_o | output | 1 | First-pass write refused because the page is not erased |

## Verification
In the same request, the block decodes the old contents and encodes the new word. data_o must therefore show the value that was stored while phys_o carries the new one. The bench drives second-pass writes on top of a first-pass word in which some symbols change and some keep their value, and it checks both outputs against hand-worked values in the same sample. It also drives a second-pass write onto a word that is already in the second pass, where some changed groups fail and others succeed. In that case the error flag and the partially cleared word must both appear together.

// File: rtl/wom2_pkg.sv
`timescale 1ns/1ps
package wom2_pkg;
  localparam int unsigned SYM_W  = 2;
  localparam int unsigned CELL_W = 3;

  function automatic logic [CELL_W-1:0] enc_first(input logic [SYM_W-1:0] s);
    case (s)
      2'b00:   enc_first = 3'b111;
      2'b01:   enc_first = 3'b110;
      2'b10:   enc_first = 3'b101;
      default: enc_first = 3'b011;
    endcase
  endfunction

  function automatic logic [CELL_W-1:0] enc_second(input logic [SYM_W-1:0] s);
    case (s)
      2'b00:   enc_second = 3'b000;
      2'b01:   enc_second = 3'b001;
      2'b10:   enc_second = 3'b010;
      default: enc_second = 3'b100;
    endcase
  endfunction

  // second-pass shaped pattern -> symbol
  function automatic logic [SYM_W-1:0] dec_light(input logic [CELL_W-1:0] c);
    case (c)
      3'b001:  dec_light = 2'b01;
      3'b010:  dec_light = 2'b10;
      3'b100:  dec_light = 2'b11;
      default: dec_light = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/wom2_sym_dec.sv
`timescale 1ns/1ps
module wom2_sym_dec
  import wom2_pkg::*;
(
  input  logic [CELL_W-1:0] cells_i,
  output logic [SYM_W-1:0]  sym_o,
  output logic              heavy_o
);
  logic [1:0] ones;

  always_comb begin
    ones    = {1'b0, cells_i[0]} + {1'b0, cells_i[1]} + {1'b0, cells_i[2]};
    heavy_o = (ones >= 2'd2);
    // first-pass words are complements of second-pass words
    sym_o   = heavy_o ? dec_light(~cells_i) : dec_light(cells_i);
  end
endmodule

// File: rtl/wom2_sym_upd.sv
`timescale 1ns/1ps
module wom2_sym_upd
  import wom2_pkg::*;
(
  input  logic              pass_i,
  input  logic [CELL_W-1:0] cells_i,
  input  logic [SYM_W-1:0]  old_sym_i,
  input  logic [SYM_W-1:0]  new_sym_i,
  output logic [CELL_W-1:0] cells_o,
  output logic              miss_o
);
  logic [CELL_W-1:0] target;
  logic              keep;

  always_comb begin
    target  = pass_i ? enc_second(new_sym_i) : enc_first(new_sym_i);
    keep    = pass_i && (old_sym_i == new_sym_i);
    cells_o = keep ? cells_i : (cells_i & target);
    miss_o  = !keep && (cells_o != target);
  end
endmodule

// File: rtl/wom2_codec.sv
`timescale 1ns/1ps
module wom2_codec
  import wom2_pkg::*;
#(
  parameter int unsigned NUM_SYM = 8,
  localparam int unsigned LW = NUM_SYM * SYM_W,
  localparam int unsigned PW = NUM_SYM * CELL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          pass_i,
  input  logic [LW-1:0] data_i,
  input  logic [PW-1:0] phys_i,
  output logic          valid_o,
  output logic [PW-1:0] phys_o,
  output logic [LW-1:0] data_o,
  output logic          prog_err_o,
  output logic          proto_err_o
);
  logic [LW-1:0]      old_word;
  logic [PW-1:0]      upd_word;
  logic [NUM_SYM-1:0] miss_vec;
  logic [NUM_SYM-1:0] heavy_vec;
  logic               refuse;
  logic [PW-1:0]      phys_nxt;

  for (genvar k = 0; k < NUM_SYM; k++) begin : g_sym
    wom2_sym_dec u_dec (
      .cells_i (phys_i[k*CELL_W +: CELL_W]),
      .sym_o   (old_word[k*SYM_W +: SYM_W]),
      .heavy_o (heavy_vec[k])
    );
    wom2_sym_upd u_upd (
      .pass_i    (pass_i),
      .cells_i   (phys_i[k*CELL_W +: CELL_W]),
      .old_sym_i (old_word[k*SYM_W +: SYM_W]),
      .new_sym_i (data_i[k*SYM_W +: SYM_W]),
      .cells_o   (upd_word[k*CELL_W +: CELL_W]),
      .miss_o    (miss_vec[k])
    );
  end

  always_comb begin
    refuse   = !pass_i && !(&phys_i);
    phys_nxt = refuse ? phys_i : upd_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      phys_o      <= '1;
      data_o      <= '0;
      prog_err_o  <= 1'b0;
      proto_err_o <= 1'b0;
    end else begin
      valid_o     <= req_i;
      prog_err_o  <= req_i && !refuse && (|miss_vec);
      proto_err_o <= req_i && refuse;
      if (req_i) begin
        phys_o <= phys_nxt;
        data_o <= old_word;
      end
    end
  end
endmodule

// File: rtl/wom2_codec_chk.sv
`timescale 1ns/1ps
module wom2_codec_chk #(
  parameter int unsigned LW = 16,
  parameter int unsigned PW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          pass_i,
  input logic [LW-1:0] data_i,
  input logic [PW-1:0] phys_i,
  input logic          valid_o,
  input logic [PW-1:0] phys_o,
  input logic [LW-1:0] data_o,
  input logic          prog_err_o,
  input logic          proto_err_o
);
  assert_valid_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !prog_err_o && !proto_err_o && $stable(phys_o) && $stable(data_o)));

  assert_no_raise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ((phys_o & ~$past(phys_i)) == '0));

  assert_refuse_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !pass_i && !(&phys_i)) |=> (proto_err_o && !prog_err_o && phys_o == $past(phys_i)));

  assert_second_never_refused_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && pass_i) |=> !proto_err_o);

  assert_first_clean_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !pass_i && (&phys_i)) |=> (!proto_err_o && !prog_err_o));
endmodule

bind wom2_codec wom2_codec_chk #(.LW(LW), .PW(PW)) u_chk (.*);

// File: tb/tb_wom2_codec.sv
`timescale 1ns/1ps
module tb_wom2_codec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        pass_i = 1'b0;
  logic [15:0] data_i = '0;
  logic [23:0] phys_i = '1;
  logic        valid_o;
  logic [23:0] phys_o;
  logic [15:0] data_o;
  logic        prog_err_o;
  logic        proto_err_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  wom2_codec dut (.*);

  typedef struct packed {
    logic        pass;
    logic [15:0] din;
    logic [23:0] pin;
    logic [23:0] ephys;
    logic [15:0] edata;
    logic        eprog;
    logic        eproto;
  } vec_t;

  // octal digit k of a physical word = symbol k
  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'hE4E4, 24'o77777777, 24'o35673567, 16'h0000, 1'b0, 1'b0},
    '{1'b1, 16'hE4E4, 24'o35673567, 24'o35673567, 16'hE4E4, 1'b0, 1'b0},
    '{1'b1, 16'h1B1B, 24'o35673567, 24'o01240124, 16'hE4E4, 1'b0, 1'b0},
    '{1'b1, 16'h00FF, 24'o77777777, 24'o77774444, 16'h0000, 1'b0, 1'b0},
    '{1'b1, 16'h6C6C, 24'o01240124, 24'o00000000, 16'h1B1B, 1'b1, 1'b0},
    '{1'b0, 16'h1234, 24'o35673567, 24'o35673567, 16'hE4E4, 1'b0, 1'b1},
    '{1'b1, 16'h24E6, 24'o35673567, 24'o05673562, 16'hE4E4, 1'b0, 1'b0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: tag_of = "R1 R10";
      1: tag_of = "R3 R4";
      2: tag_of = "R2 R4";
      3: tag_of = "R2 R3";
      4: tag_of = "R6 R5";
      5: tag_of = "R7";
      default: tag_of = "R3 R2 R10";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic p, input logic [15:0] d, input logic [23:0] s);
    @(negedge clk_i);
    req_i  = 1'b1;
    pass_i = p;
    data_i = d;
    phys_i = s;
    @(negedge clk_i);
    req_i  = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #5;
    chk("R9", "valid", {23'd0, valid_o}, 24'd0);
    chk("R9", "phys", phys_o, 24'hFFFFFF);
    chk("R9", "data", {8'd0, data_o}, 24'd0);
    chk("R9", "flags", {22'd0, prog_err_o, proto_err_o}, 24'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].pass, VEC[i].din, VEC[i].pin);
      chk(tag_of(i), "valid R8", {23'd0, valid_o}, 24'd1);
      chk(tag_of(i), "phys", phys_o, VEC[i].ephys);
      chk(tag_of(i), "data", {8'd0, data_o}, {8'd0, VEC[i].edata});
      chk(tag_of(i), "prog_err", {23'd0, prog_err_o}, {23'd0, VEC[i].eprog});
      chk(tag_of(i), "proto_err", {23'd0, proto_err_o}, {23'd0, VEC[i].eproto});
    end

    // R8: idle cycles keep the result, pulse ends; new input is not taken
    phys_i = 24'o12341234;
    data_i = 16'hFFFF;
    repeat (3) @(negedge clk_i);
    chk("R8", "idle valid", {23'd0, valid_o}, 24'd0);
    chk("R8", "idle phys hold", phys_o, 24'o05673562);
    chk("R8", "idle data hold", {8'd0, data_o}, 24'h00E4E4);

    // back-to-back requests: each result one cycle later
    @(negedge clk_i);
    req_i = 1'b1; pass_i = 1'b1; data_i = 16'h0000; phys_i = 24'o77777777;
    @(negedge clk_i);
    chk("R8", "b2b first phys", phys_o, 24'o77777777);
    pass_i = 1'b0; data_i = 16'h0003; phys_i = 24'o77777777;
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R8", "b2b second valid", {23'd0, valid_o}, 24'd1);
    chk("R10", "b2b second phys", phys_o, 24'o77777773);
    @(negedge clk_i);
    chk("R8", "pulse ends", {23'd0, valid_o}, 24'd0);

    // R4: single-ones words in the second-pass codebook
    issue(1'b1, 16'h0000, 24'o00001240);
    chk("R4", "decode light", {8'd0, data_o}, 24'h00006C);

    // R9: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R9", "reset phys", phys_o, 24'hFFFFFF);
    chk("R9", "reset data", {8'd0, data_o}, 24'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule